// File: doc/BRIEF.md
# UART Register Front-End on APB

This block is the register front-end of a UART. It sits on an APB slave port and connects to a byte-wide receive stream, a byte-wide transmit stream and one interrupt line. Serial timing is handled elsewhere. Software writes a control word to enable reception, transmission and their interrupts. It reads a status word to learn whether received bytes are waiting. It takes received bytes out of a small buffer one at a time by reading the data location. Every byte it writes to the data location leaves on the transmit stream.

The receive buffer fills in a straight line: bytes land at increasing slots, and reads advance a read pointer behind them. Space comes back only when software has read every stored byte. At that moment both pointers return to zero. The transmit side has no storage, so status always reports the transmitter as idle and empty. Interrupts are single-cycle pulses, one per stored byte or transmitted byte, when the matching enable is set.

Top module: `urf_apb_uart`

## Requirements
- R1: After reset the control word reads 0, status reads 0x0000_0006 (bit 1 and bit 2, the transmitter-idle and transmitter-empty flags, set), the buffer is empty and rx_ready is high.
- R2: Only paddr[7:0] is decoded. Offset 0x00 and offset 0x03 both reach the data location with identical read and write behaviour. Address bits above bit 7 have no effect.
- R3: A write to offset 0x08 replaces all 32 bits of the control word. Reading offset 0x08 returns the value last written.
- R4: Writes to status (0x04) are ignored. The scaler (0x0C), debug (0x10) and every unmapped offset read as zero. Writes to them change nothing.
- R5: A byte taken from the receive stream is stored only when control bit 0 (receive enable) is set. Otherwise the byte is accepted and dropped.
- R6: Status bit 0 (data ready) is set while at least one stored byte is unread and clears once the last one is read.
- R7: A read of the data location returns the oldest unread byte, zero-extended to 32 bits, and consumes it. A read of an empty buffer returns zero and changes nothing.
- R8: rx_ready is low while the write count equals DEPTH, even after some bytes have been read. Once every byte is read, both pointers return to zero and rx_ready rises.
- R9: A data write with control bit 1 (transmit enable) set puts pwdata[7:0] on tx_data with tx_valid high for one cycle, in the cycle after the access phase. When that bit is clear, nothing is emitted.
- R10: irq pulses for one cycle after a stored byte when control bit 2 is set. It also pulses after an emitted byte when control bit 3 is set. It stays low otherwise.
- R11: When a data read takes the last stored byte in the same cycle that a new byte is stored, the new byte is kept and data ready stays set.
- R12: Every transfer completes in one access phase with pready high and pslverr low. A byte is consumed only in the access phase, never in the setup phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | AW | APB address, low 8 bits decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Buffer can accept a byte |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | One-cycle strobe for tx_data |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench fills the buffer to DEPTH and then reads one byte. A design that reused freed slots early would raise rx_ready at that point, when it should stay low until the buffer is fully drained. It lands a push in the same cycle as the pop of the last byte. A design that flushed after the push would lose the new byte and clear data ready. It also holds a read in its setup phase for several cycles, and reads through offset 0x03 and through addresses with high bits set. A front-end that popped per cycle or decoded too many bits would return the wrong byte order. A scoreboard checks every transmitted byte against the expected stream. It catches bytes emitted while transmit is disabled and interrupt pulses that do not match their enables.

// File: rtl/urf_pkg.sv
package urf_pkg;
   localparam logic [7:0] OFS_DATA   = 8'h00;
   localparam logic [7:0] OFS_DATA_B = 8'h03;
   localparam logic [7:0] OFS_STAT   = 8'h04;
   localparam logic [7:0] OFS_CTRL   = 8'h08;
   localparam logic [7:0] OFS_SCAL   = 8'h0C;
   localparam logic [7:0] OFS_DBG    = 8'h10;

   localparam int CB_RXEN = 0;
   localparam int CB_TXEN = 1;
   localparam int CB_RXIE = 2;
   localparam int CB_TXIE = 3;

   localparam int SB_DRDY = 0;
   localparam int SB_TSE  = 1;
   localparam int SB_TFE  = 2;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_STAT,
      SEL_CTRL,
      SEL_INERT
   } reg_sel_e;
endpackage

// File: rtl/urf_decode.sv
module urf_decode
   import urf_pkg::*;
(
   input  logic [7:0] ofs,
   output reg_sel_e   sel
);
   always_comb begin
      unique case (ofs)
         OFS_DATA, OFS_DATA_B: sel = SEL_DATA;
         OFS_STAT:             sel = SEL_STAT;
         OFS_CTRL:             sel = SEL_CTRL;
         OFS_SCAL, OFS_DBG:    sel = SEL_INERT;
         default:              sel = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/urf_rxbuf.sv
module urf_rxbuf #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head_data,
   output logic          nonempty,
   output logic          has_room
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("urf_rxbuf: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("urf_rxbuf: DW must be positive");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [CW-1:0] wcnt, rptr;
   logic [CW-1:0] wr_idx;
   logic          do_pop, drained;

   assign nonempty = (rptr != wcnt);
   assign has_room = (wcnt < CW'(DEPTH));
   assign do_pop   = pop && nonempty;
   assign drained  = do_pop && ((rptr + CW'(1)) == wcnt);
   assign wr_idx   = drained ? '0 : wcnt;
   assign head_data = nonempty ? mem[rptr[IW-1:0]] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt <= '0;
         rptr <= '0;
      end else if (drained) begin
         rptr <= '0;
         wcnt <= push ? CW'(1) : '0;
      end else begin
         if (do_pop) rptr <= rptr + CW'(1);
         if (push)   wcnt <= wcnt + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_idx[IW-1:0]] <= push_data;
   end

   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wcnt <= CW'(DEPTH)) && (rptr <= wcnt));

   assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && nonempty && ((rptr + CW'(1)) == wcnt) && !push) |=> (wcnt == '0 && rptr == '0));

   assert_keep_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && nonempty && ((rptr + CW'(1)) == wcnt) && push) |=> nonempty);
endmodule

// File: rtl/urf_apb_uart.sv
module urf_apb_uart
   import urf_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 12
) (
   input  logic          pclk,
   input  logic          presetn,
   input  logic          psel,
   input  logic          penable,
   input  logic          pwrite,
   input  logic [AW-1:0] paddr,
   input  logic [31:0]   pwdata,
   output logic [31:0]   prdata,
   output logic          pready,
   output logic          pslverr,
   input  logic [7:0]    rx_data,
   input  logic          rx_valid,
   output logic          rx_ready,
   output logic [7:0]    tx_data,
   output logic          tx_valid,
   output logic          irq
);
   generate
      if (AW < 8) begin : g_bad_aw
         $error("urf_apb_uart: AW must be at least 8");
      end
   endgenerate

   reg_sel_e    sel;
   logic        access, rd_data, wr_data, wr_ctrl;
   logic        push, buf_nonempty;
   logic [7:0]  head;
   logic [31:0] ctrl_q, status;

   urf_decode u_dec (.ofs(paddr[7:0]), .sel(sel));

   assign access  = psel && penable;
   assign rd_data = access && !pwrite && (sel == SEL_DATA);
   assign wr_data = access &&  pwrite && (sel == SEL_DATA);
   assign wr_ctrl = access &&  pwrite && (sel == SEL_CTRL);
   assign push    = rx_valid && rx_ready && ctrl_q[CB_RXEN];

   urf_rxbuf #(.DEPTH(DEPTH), .DW(8)) u_rxbuf (
      .clk      (pclk),
      .rst_n    (presetn),
      .push     (push),
      .push_data(rx_data),
      .pop      (rd_data),
      .head_data(head),
      .nonempty (buf_nonempty),
      .has_room (rx_ready)
   );

   always_comb begin
      status          = '0;
      status[SB_DRDY] = buf_nonempty;
      status[SB_TSE]  = 1'b1;
      status[SB_TFE]  = 1'b1;
   end

   always_comb begin
      prdata = '0;
      if (access && !pwrite) begin
         unique case (sel)
            SEL_DATA: prdata = {24'h0, head};
            SEL_STAT: prdata = status;
            SEL_CTRL: prdata = ctrl_q;
            default:  prdata = '0;
         endcase
      end
   end

   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         ctrl_q   <= '0;
         tx_valid <= 1'b0;
         tx_data  <= '0;
         irq      <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= pwdata;
         tx_valid <= wr_data && ctrl_q[CB_TXEN];
         if (wr_data && ctrl_q[CB_TXEN]) tx_data <= pwdata[7:0];
         irq <= (push && ctrl_q[CB_RXIE])
              || (wr_data && ctrl_q[CB_TXEN] && ctrl_q[CB_TXIE]);
      end
   end

   assert_tx_gate_R9: assert property (@(posedge pclk) disable iff (!presetn)
      tx_valid |-> $past(ctrl_q[CB_TXEN]));

   assert_irq_src_R10: assert property (@(posedge pclk) disable iff (!presetn)
      irq |-> $past(ctrl_q[CB_RXIE] || ctrl_q[CB_TXIE]));

   assert_store_R6: assert property (@(posedge pclk) disable iff (!presetn)
      push |=> buf_nonempty);

   assert_no_store_R5: assert property (@(posedge pclk) disable iff (!presetn)
      (!buf_nonempty && !ctrl_q[CB_RXEN]) |=> !buf_nonempty);
endmodule

// File: tb/urf_apb_uart_tb.sv
`timescale 1ns/1ps
module urf_apb_uart_tb;
   localparam int DEPTH = 16;
   localparam int AW    = 12;
   localparam real HALF = 2.5;

   logic          pclk = 1'b0;
   logic          presetn = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [31:0]   pwdata = '0;
   logic [31:0]   prdata;
   logic          pready, pslverr;
   logic [7:0]    rx_data = '0;
   logic          rx_valid = 1'b0;
   logic          rx_ready;
   logic [7:0]    tx_data;
   logic          tx_valid, irq;

   int tests = 0, fails = 0;
   int irq_seen = 0, irq_exp = 0;
   logic [7:0] txq [$];

   always #(HALF) pclk = ~pclk;

   urf_apb_uart #(.DEPTH(DEPTH), .AW(AW)) u_dut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_data(tx_data),
      .tx_valid(tx_valid), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // monitor: transmit scoreboard and interrupt counter
   always @(negedge pclk) begin
      if (presetn) begin
         if (irq) irq_seen++;
         if (tx_valid) begin
            if (txq.size() == 0) chk(1'b0, "R9 unexpected tx", {24'h0, tx_data}, 32'h0);
            else begin
               logic [7:0] e;
               e = txq.pop_front();
               chk(tx_data == e, "R9 tx byte", {24'h0, tx_data}, {24'h0, e});
            end
         end
      end
   end

   task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      @(negedge pclk); penable = 1;
      @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
      @(negedge pclk); penable = 1;
      #1 d = prdata;
      @(negedge pclk); psel = 0; penable = 0;
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
      logic [31:0] d;
      apb_rd(a, d);
      chk(d == exp, req, d, exp);
   endtask

   task automatic rx_send(input logic [7:0] b);
      @(negedge pclk); rx_valid = 1; rx_data = b;
      @(negedge pclk); rx_valid = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge pclk);
   endtask

   initial begin
      #(HALF * 2 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      idle(4);
      presetn = 1;
      idle(2);

      // R1 reset state
      rd_chk(12'h004, 32'h6, "R1 status at reset");
      rd_chk(12'h008, 32'h0, "R1 control at reset");
      chk(rx_ready == 1'b1, "R1 rx_ready at reset", {31'h0, rx_ready}, 1);
      rd_chk(12'h000, 32'h0, "R7 empty read");

      // R5 receive disabled drops byte
      rx_send(8'h11);
      rd_chk(12'h004, 32'h6, "R5 no store when disabled");
      rd_chk(12'h000, 32'h0, "R5 nothing buffered");

      // R3 control full-width write
      apb_wr(12'h008, 32'hA5A5_F0F0);
      rd_chk(12'h008, 32'hA5A5_F0F0, "R3 control readback");
      apb_wr(12'h008, 32'h5);
      rd_chk(12'h008, 32'h5, "R3 control replaced");

      // R6/R7/R2/R10 receive path with interrupts
      irq_exp = irq_seen;
      rx_send(8'h41); rx_send(8'h42); rx_send(8'h43);
      irq_exp += 3;
      idle(2);
      chk(irq_seen == irq_exp, "R10 rx irq count", irq_seen, irq_exp);
      rd_chk(12'h004, 32'h7, "R6 data ready set");
      rd_chk(12'h003, 32'h41, "R2 data at offset 3");
      rd_chk(12'h000, 32'h42, "R7 second byte");
      rd_chk(12'h300, 32'h43, "R2 upper address bits ignored");
      rd_chk(12'h004, 32'h6, "R6 data ready clears");
      rd_chk(12'h000, 32'h0, "R7 empty read after drain");

      // R4 inert locations
      apb_wr(12'h004, 32'hFFFF_FFFF);
      rd_chk(12'h004, 32'h6, "R4 status write ignored");
      apb_wr(12'h00C, 32'h123);
      rd_chk(12'h00C, 32'h0, "R4 scaler reads zero");
      apb_wr(12'h010, 32'h456);
      rd_chk(12'h010, 32'h0, "R4 debug reads zero");
      rd_chk(12'h014, 32'h0, "R4 unmapped reads zero");
      rd_chk(12'h008, 32'h5, "R4 control untouched");

      // R9/R10 transmit path
      irq_exp = irq_seen;
      apb_wr(12'h008, 32'h2);
      txq.push_back(8'hAB);
      apb_wr(12'h000, 32'h1AB);
      apb_wr(12'h008, 32'hA);
      txq.push_back(8'h5C);
      apb_wr(12'h003, 32'h5C);
      irq_exp += 1;
      apb_wr(12'h008, 32'h8);
      apb_wr(12'h000, 32'h77);
      idle(2);
      chk(txq.size() == 0, "R9 all expected bytes sent", txq.size(), 0);
      chk(irq_seen == irq_exp, "R10 tx irq count", irq_seen, irq_exp);

      // R8 linear fill and drain
      apb_wr(12'h008, 32'h1);
      for (int i = 0; i < DEPTH; i++) rx_send(8'h80 + 8'(i));
      idle(1);
      chk(rx_ready == 1'b0, "R8 full blocks", {31'h0, rx_ready}, 0);
      rd_chk(12'h000, 32'h80, "R8 first byte");
      chk(rx_ready == 1'b0, "R8 still blocked after partial read", {31'h0, rx_ready}, 0);
      for (int i = 1; i < DEPTH; i++) rd_chk(12'h000, 32'h80 + 32'(i), "R7 order in fill");
      chk(rx_ready == 1'b1, "R8 room after drain", {31'h0, rx_ready}, 1);

      // R11 pop of last byte with simultaneous push
      rx_send(8'h21);
      @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = 12'h000;
      @(negedge pclk); penable = 1; rx_valid = 1; rx_data = 8'h22;
      #1 d = prdata;
      chk(d == 32'h21, "R11 popped byte", d, 32'h21);
      chk(pready == 1'b1 && pslverr == 1'b0, "R12 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);
      @(negedge pclk); psel = 0; penable = 0; rx_valid = 0;
      rd_chk(12'h004, 32'h7, "R11 data ready kept");
      rd_chk(12'h000, 32'h22, "R11 pushed byte kept");
      rd_chk(12'h004, 32'h6, "R11 drained");

      // R12 setup phase does not pop
      rx_send(8'h31);
      @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = 12'h000;
      idle(3);
      psel = 0;
      rd_chk(12'h000, 32'h31, "R12 setup phase no pop");
      rd_chk(12'h000, 32'h0, "R12 single pop per transfer");

      idle(2);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule